// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block tracks the position of a rotary or linear encoder from its two phase inputs, A and B. A 2-bit source field selects one of four ways to turn those inputs into counts. The first is full quadrature decode, which gives four counts per encoder cycle. The second treats A as a pulse and B as a direction level. The last two count up only or down only from A. Both encoder inputs are synchronised to the core clock before their edges are examined.

Software sees four registers on a small word-wide port. The 32-bit position register can be read and written. The 32-bit maximum register bounds the counting range, and the count wraps at both ends of that range. The decoder-control register holds the source field and the edge-qualifier bit. The general-control register holds the counting enable.

Top module: `qpc_counter`

## Requirements
- R1: After reset, the position reads 0, the maximum reads 0xFFFF_FFFF, and decoder control and general control both read 0.
- R2: The registers sit at these byte offsets. Position is at 0x00 and maximum at 0x08, both 32 bits. Decoder control is at 0x28 and general control is at 0x2A, both 16 bits and zero-extended on read. Decoder control bits 15:14 select the source: 0 is quadrature, 1 is pulse/direction, 2 is up-only and 3 is down-only. Decoder control bit 11 is the dual-edge qualifier. General control bit 3 is the counting enable.
- R3: While the enable bit is 0, encoder activity leaves the position unchanged.
- R4: In quadrature mode, the pair {A,B} stepping 00→01→11→10→00 adds one per step, and the reverse order subtracts one per step.
- R5: In quadrature mode, a change of A and B in the same sampled step is illegal and produces no count.
- R6: In pulse/direction mode, only a rising edge of A counts. It counts up when B is 1 and down when B is 0. Falling edges of A and any edge of B do not count.
- R7: In up-only mode (source 2) the position only increments, and in down-only mode (source 3) it only decrements. In both modes B is ignored. A rising edge of A always counts. A falling edge of A counts only when decoder control bit 11 is 1.
- R8: A count up from a position at the maximum gives 0. A count down from 0 gives the maximum.
- R9: A software write to the position is accepted when the written value is no larger than the maximum. A larger value is ignored and the position keeps its old value.
- R10: A and B each pass through a two-flop synchroniser. An input change that is set up before rising clock edge k shows in the position after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |

## Verification
The bench steps {A,B} through forward and reverse Gray sequences and through double-bit jumps. A decoder that uses the wrong direction equation would count backwards, and one that lets an illegal jump through would drift. It then drives the count across both ends of a small maximum in the up-only and down-only modes. A design that wraps at the full 32-bit range, or reloads the wrong end, shows a position outside the range. It also writes values one above and equal to the maximum, which exposes a write check that is missing or off by one. It times a single edge through the synchronisers to catch a missing or extra flop. A fixed-seed random walk mixes all four modes, the dual-edge bit and the enable, with an oversized write from time to time.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CTL_W   = 16;
  localparam int unsigned SYNC_N  = 2;

  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_DIR  = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_e;

  localparam logic [ADDR_W-1:0] OFF_POS = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_MAX = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DEC = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_CTL = 6'h2A;

  localparam int unsigned SRC_MSB  = 15;
  localparam int unsigned SRC_LSB  = 14;
  localparam int unsigned DUAL_BIT = 11;
  localparam int unsigned EN_BIT   = 3;
endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/qpc_step_decode.sv
module qpc_step_decode
  import qpc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  src_e src_i,
  input  logic dual_i,
  output logic a_prev_o,
  output logic b_prev_o,
  output logic up_o,
  output logic dn_o
);
  logic a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  logic a_rise, a_fall, single, fwd, a_edge;
  assign a_rise = a_i & ~a_q;
  assign a_fall = ~a_i & a_q;
  assign single = (a_i ^ a_q) ^ (b_i ^ b_q);
  // forward Gray order on {A,B}: old A differs from new B
  assign fwd    = a_q ^ b_i;
  assign a_edge = a_rise | (dual_i & a_fall);

  always_comb begin
    up_o = 1'b0;
    dn_o = 1'b0;
    unique case (src_i)
      SRC_QUAD: begin
        up_o = single & fwd;
        dn_o = single & ~fwd;
      end
      SRC_DIR: begin
        up_o = a_rise & b_i;
        dn_o = a_rise & ~b_i;
      end
      SRC_UP:   up_o = a_edge;
      SRC_DOWN: dn_o = a_edge;
      default: ;
    endcase
  end

  assign a_prev_o = a_q;
  assign b_prev_o = b_q;
endmodule

// File: rtl/qpc_pos_reg.sv
module qpc_pos_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] max_i,
  output logic [WIDTH-1:0] pos_o
);
  logic [WIDTH-1:0] pos_q;
  logic             wr_ok;

  assign wr_ok = wr_i && (wdata_i <= max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (wr_ok) begin
      pos_q <= wdata_i;
    end else if (en_i && up_i) begin
      pos_q <= (pos_q >= max_i) ? '0 : pos_q + 1'b1;
    end else if (en_i && dn_i) begin
      pos_q <= (pos_q == '0) ? max_i : pos_q - 1'b1;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
  import qpc_pkg::*;
#(
  parameter logic [DATA_W-1:0] MAX_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic [DATA_W-1:0] pos_max_q, pos;
  logic [CTL_W-1:0]  dec_ctl_q, gen_ctl_q;
  logic [1:0]        enc_sync;
  logic              a_prev, b_prev, step_up, step_dn, cnt_en;
  src_e              src_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_max_q <= MAX_RST;
      dec_ctl_q <= '0;
      gen_ctl_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == OFF_MAX) pos_max_q <= reg_wdata_i;
      if (reg_addr_i == OFF_DEC) dec_ctl_q <= reg_wdata_i[CTL_W-1:0];
      if (reg_addr_i == OFF_CTL) gen_ctl_q <= reg_wdata_i[CTL_W-1:0];
    end
  end

  assign src_sel = src_e'(dec_ctl_q[SRC_MSB:SRC_LSB]);
  assign cnt_en  = gen_ctl_q[EN_BIT];

  qpc_sync #(.WIDTH(2), .STAGES(SYNC_N)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enc_b_i, enc_a_i}),
    .q_o    (enc_sync)
  );

  qpc_step_decode i_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (enc_sync[0]),
    .b_i      (enc_sync[1]),
    .src_i    (src_sel),
    .dual_i   (dec_ctl_q[DUAL_BIT]),
    .a_prev_o (a_prev),
    .b_prev_o (b_prev),
    .up_o     (step_up),
    .dn_o     (step_dn)
  );

  qpc_pos_reg #(.WIDTH(DATA_W)) i_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en),
    .up_i    (step_up),
    .dn_i    (step_dn),
    .wr_i    (reg_we_i && (reg_addr_i == OFF_POS)),
    .wdata_i (reg_wdata_i),
    .max_i   (pos_max_q),
    .pos_o   (pos)
  );

  always_comb begin
    case (reg_addr_i)
      OFF_POS: reg_rdata_o = pos;
      OFF_MAX: reg_rdata_o = pos_max_q;
      OFF_DEC: reg_rdata_o = {{(DATA_W-CTL_W){1'b0}}, dec_ctl_q};
      OFF_CTL: reg_rdata_o = {{(DATA_W-CTL_W){1'b0}}, gen_ctl_q};
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker
  import qpc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              up,
  input logic              dn,
  input logic              a_s,
  input logic              b_s,
  input logic              a_d,
  input logic              b_d,
  input logic [1:0]        src,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] pos,
  input logic [DATA_W-1:0] pmax
);
  logic pos_wr;
  assign pos_wr = we && (addr == OFF_POS);

  assert_hold_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !pos_wr) |=> $stable(pos));

  assert_one_direction_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up && dn));

  assert_no_illegal_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == SRC_QUAD && a_s != a_d && b_s != b_d) |-> !(up || dn));

  assert_b_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src[1] && a_s == a_d) |-> !(up || dn));

  assert_wrap_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && up && pos == pmax && !we) |=> pos == '0);

  assert_wrap_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && dn && pos == '0 && !we) |=> pos == pmax);

  assert_oversize_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_wr && wdata > pmax && !(en && (up || dn))) |=> $stable(pos));

  assert_legal_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_wr && wdata <= pmax) |=> pos == $past(wdata));
endmodule

bind qpc_counter qpc_checker i_qpc_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en    (cnt_en),
  .up    (step_up),
  .dn    (step_dn),
  .a_s   (enc_sync[0]),
  .b_s   (enc_sync[1]),
  .a_d   (a_prev),
  .b_d   (b_prev),
  .src   (dec_ctl_q[15:14]),
  .we    (reg_we_i),
  .addr  (reg_addr_i),
  .wdata (reg_wdata_i),
  .pos   (pos),
  .pmax  (pos_max_q)
);

// File: tb/test_qpc_counter.sv
`timescale 1ns/1ps
module test_qpc_counter;
  localparam logic [5:0] A_POS = 6'h00, A_MAX = 6'h08, A_DEC = 6'h28, A_CTL = 6'h2A;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        enc_a_i = 1'b0, enc_b_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_rdata_o;

  always #5 clk_i = ~clk_i;

  qpc_counter i_qpc_counter (.*);

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_pos = '0, m_max = 32'hFFFF_FFFF;
  logic [1:0]  m_mode = '0;
  bit          m_dual = 0, m_en = 0, cur_a = 0, cur_b = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i); reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i); reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i); reg_we_i = 1'b0;
    case (a)
      A_POS: if (d <= m_max) exp_pos = d;
      A_MAX: m_max = d;
      A_DEC: begin m_mode = d[15:14]; m_dual = d[11]; end
      A_CTL: m_en = d[3];
      default: ;
    endcase
  endtask

  function automatic int gidx(bit a, bit b);
    case ({a, b})
      2'b00: return 0; 2'b01: return 1; 2'b11: return 2; default: return 3;
    endcase
  endfunction

  function automatic int delta(bit pa, bit pb, bit na, bit nb);
    int d;
    if (!m_en) return 0;
    case (m_mode)
      2'd0: begin
        d = (gidx(na, nb) - gidx(pa, pb) + 4) % 4;
        return (d == 1) ? 1 : (d == 3) ? -1 : 0;
      end
      2'd1: return (!pa && na) ? (nb ? 1 : -1) : 0;
      default: begin
        if ((!pa && na) || (m_dual && pa && !na)) return (m_mode == 2'd2) ? 1 : -1;
        return 0;
      end
    endcase
  endfunction

  function automatic logic [31:0] apply(logic [31:0] p, int d, logic [31:0] mx);
    if (d > 0) return (p >= mx) ? 32'd0 : p + 1;
    if (d < 0) return (p == 0) ? mx : p - 1;
    return p;
  endfunction

  task automatic move(bit na, bit nb);
    int d;
    d = delta(cur_a, cur_b, na, nb);
    @(negedge clk_i); enc_a_i = na; enc_b_i = nb;
    repeat (3) @(posedge clk_i);
    exp_pos = apply(exp_pos, d, m_max);
    cur_a = na; cur_b = nb;
  endtask

  task automatic chk_pos(string req);
    logic [31:0] v;
    rd(A_POS, v);
    chk(req, v, exp_pos);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 reset values
    rd(A_POS, v); chk("R1 pos", v, 32'h0);
    rd(A_MAX, v); chk("R1 max", v, 32'hFFFF_FFFF);
    rd(A_DEC, v); chk("R1 dec", v, 32'h0);
    rd(A_CTL, v); chk("R1 ctl", v, 32'h0);

    // R2 register map readback
    wr(A_MAX, 32'h64);       rd(A_MAX, v); chk("R2 max", v, 32'h64);
    wr(A_DEC, 32'hFFFF_C800); rd(A_DEC, v); chk("R2 dec 16b", v, 32'h0000_C800);
    wr(A_CTL, 32'h0000_0008); rd(A_CTL, v); chk("R2 ctl", v, 32'h8);
    wr(A_CTL, 32'h0); wr(A_DEC, 32'h0);

    // R3 disabled: quadrature steps ignored
    move(0, 1); move(1, 1); move(1, 0); move(0, 0);
    rd(A_POS, v); chk("R3 hold", v, 32'h0);

    // R4 forward then reverse
    wr(A_CTL, 32'h8);
    move(0, 1); move(1, 1); move(1, 0); move(0, 0);
    rd(A_POS, v); chk("R4 fwd", v, 32'd4);
    move(1, 0); move(1, 1);
    rd(A_POS, v); chk("R4 rev", v, 32'd2);

    // R5 illegal jumps
    move(0, 0); move(1, 1);
    rd(A_POS, v); chk("R5 illegal", v, 32'd2);

    // R10 latency: 11 -> 10 is a forward step
    @(negedge clk_i); reg_addr_i = A_POS; enc_b_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); #1;
    chk("R10 not yet", reg_rdata_o, 32'd2);
    @(posedge clk_i); #1;
    chk("R10 counted", reg_rdata_o, 32'd3);
    exp_pos = 32'd3; cur_b = 0;
    move(0, 0); chk_pos("R4 step to 00");

    // R6 pulse/direction
    wr(A_DEC, 32'h4000);
    move(0, 1); chk_pos("R6 B edge");
    move(1, 1); rd(A_POS, v); chk("R6 up", v, 32'd5);
    move(0, 1); rd(A_POS, v); chk("R6 fall", v, 32'd5);
    move(0, 0); move(1, 0); rd(A_POS, v); chk("R6 down", v, 32'd4);

    // R7 up-only rising, then dual edge, then down-only
    wr(A_DEC, 32'h8000);
    move(0, 0); move(0, 1); move(1, 1); move(1, 0);
    rd(A_POS, v); chk("R7 up rise", v, 32'd5);
    wr(A_DEC, 32'h8800);
    move(0, 0); move(1, 1);
    rd(A_POS, v); chk("R7 up dual", v, 32'd7);
    wr(A_DEC, 32'hC000);
    move(0, 0); move(1, 0);
    rd(A_POS, v); chk("R7 down rise", v, 32'd6);

    // R9 write bound
    wr(A_POS, 32'h65); rd(A_POS, v); chk("R9 oversize", v, 32'd6);
    wr(A_POS, 32'h64); rd(A_POS, v); chk("R9 at max", v, 32'h64);

    // R8 wraps
    wr(A_DEC, 32'h8000);
    move(0, 0); move(1, 0);
    rd(A_POS, v); chk("R8 wrap up", v, 32'h0);
    wr(A_DEC, 32'hC000);
    move(0, 0); move(1, 0);
    rd(A_POS, v); chk("R8 wrap down", v, 32'h64);

    // random walk across modes
    void'($urandom(32'h1234_5A5A));
    wr(A_MAX, 32'd11);
    wr(A_POS, 32'd5);
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) wr(A_DEC, {16'h0, 2'($urandom), 2'b00, 1'($urandom), 11'h0});
      if (r == 1) wr(A_CTL, {28'h0, !m_en, 3'b0});
      if (r == 2) wr(A_POS, $urandom % (m_max + 3));
      move(1'($urandom), 1'($urandom));
      chk_pos("R4 R6 R7 R8 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule